// File: doc/BRIEF.md
# Peripheral-Mode DMA Handshake Channel

This block moves a programmed number of bytes between an outside DMA controller and a small internal byte RAM over a shared 8-bit bus. Software gives a start address, a byte count and a direction, then pulses a start input. The channel drives an active-low request and waits for the outside controller. For each byte, the controller lowers the active-low acknowledge together with either the read strobe or the write strobe.

Each completed strobe moves one byte, steps the RAM address up by one and takes one off the count. When the count reaches zero, the request is withdrawn and a done flag is set. The done flag can drive the interrupt line. The channel runs only while the device is in peripheral mode. In host mode it stays idle.

A processor access shares the RAM port and wins over DMA. A processor access is chip select low with acknowledge high.

Top module: `dma_hs_chan`

## Requirements
- R1: After reset, `dreq_n` is 1 and `done`, `irq` and `dout_en` are 0.
- R2: A `start` pulse in peripheral mode (`slave_mode`=1) with a nonzero `count_in` drives `dreq_n` low at the next clock edge. `dreq_n` stays low while bytes remain.
- R3: With `dir_in`=0 (outside to memory), each write strobe (`wr_n` low with `dack_n` low) stores `din` at the current address. When the strobe is released, the address advances by one and the count drops by one.
- R4: With `dir_in`=1 (memory to outside), while `rd_n` and `dack_n` are both low, `dout` presents the byte at the current address and `dout_en` is 1. The address advances when the strobe is released.
- R5: At the clock edge that follows the release of the last byte's strobe, `dreq_n` returns to 1 and `done` becomes 1. While `done` is 1, `dreq_n` is 1.
- R6: A `start` with `count_in`=0 sets `done` at the next edge and never lowers `dreq_n`. This also cancels any run in progress.
- R7: With `slave_mode`=0, `start` is ignored and `dreq_n` is 1 from the next edge. Clearing `slave_mode` during a run aborts that run.
- R8: When `cs_n` is low and `dack_n` is high, the RAM port serves the processor at `cpu_addr` (write on `wr_n` low, read on `rd_n` low). That access leaves the DMA count and address untouched.
- R9: `irq` equals `done` gated by `irq_en`. A new `start` with a nonzero count clears `done`.
- R10: A strobe held low for several cycles moves exactly one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_mode | input | 1 | 1 = peripheral mode; the channel runs only in this mode |
| start | input | 1 | One-cycle pulse that loads address, count and direction |
| dir_in | input | 1 | 1 = memory to outside, 0 = outside to memory |
| addr_in | input | AW | Start address in RAM |
| count_in | input | CW | Number of bytes to move |
| irq_en | input | 1 | Lets `done` drive the interrupt |
| cpu_addr | input | AW | Processor RAM address |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| dack_n | input | 1 | Active-low DMA acknowledge |
| din | input | 8 | Data from the bus |
| dreq_n | output | 1 | Active-low DMA request |
| dout | output | 8 | Data to the bus |
| dout_en | output | 1 | Bus drive enable |
| done | output | 1 | Transfer complete flag |
| irq | output | 1 | Interrupt output |

## Verification
The assertions assume that the outside controller raises a strobe only while it holds acknowledge low. They also assume that `start` is a single-cycle pulse, and that chip select and acknowledge are never low together. The bench drives every input on the falling clock edge and keeps each strobe inside its acknowledge window. It raises `cs_n` low only while `dack_n` is high, so all stimulus stays within those assumptions.

// File: rtl/dma_hs_chan.sv
module dma_hs_chan #(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slave_mode,
  input  logic          start,
  input  logic          dir_in,
  input  logic [AW-1:0] addr_in,
  input  logic [CW-1:0] count_in,
  input  logic          irq_en,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          dack_n,
  input  logic [7:0]    din,
  output logic          dreq_n,
  output logic [7:0]    dout,
  output logic          dout_en,
  output logic          done,
  output logic          irq
);
  localparam int DEPTH = 1 << AW;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] cur;
  logic [CW-1:0] cnt;
  logic          active, dir_q, stb_q;

  wire cpu_sel = !cs_n && dack_n;
  wire stb_now = slave_mode && active && !dack_n && (dir_q ? !rd_n : !wr_n);
  wire step    = stb_q && !stb_now;
  wire ram_we  = (cpu_sel && !wr_n) || (stb_now && !dir_q);
  wire [AW-1:0] ram_a = cpu_sel ? cpu_addr : cur;

  assign dout    = mem[ram_a];
  assign dout_en = (cpu_sel && !rd_n) || (stb_now && dir_q);
  assign dreq_n  = !active;
  assign irq     = done && irq_en;

  always_ff @(posedge clk)
    if (ram_we) mem[ram_a] <= din;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      done   <= 1'b0;
      dir_q  <= 1'b0;
      stb_q  <= 1'b0;
      cur    <= '0;
      cnt    <= '0;
    end else begin
      stb_q <= stb_now;
      if (!slave_mode) begin
        active <= 1'b0;
      end else if (start) begin
        cur    <= addr_in;
        cnt    <= count_in;
        dir_q  <= dir_in;
        active <= (count_in != '0);
        done   <= (count_in == '0);
        stb_q  <= 1'b0;
      end else if (step) begin
        cur <= cur + 1'b1;
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  p_req_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && slave_mode && count_in != '0) |=> !dreq_n);
  p_zero_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && slave_mode && count_in == '0) |=> (done && dreq_n));
  p_host_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !slave_mode |=> dreq_n);
  p_done_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> dreq_n);
  p_last_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && slave_mode && !start && cnt == CW'(1)) |=> (done && dreq_n));
  p_drive_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> !rd_n);
endmodule

// File: tb/sim_dma_hs_chan.sv
module sim_dma_hs_chan;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, slave_mode, start, dir_in, irq_en, cs_n, rd_n, wr_n, dack_n;
  logic [7:0] addr_in, count_in, cpu_addr, din, dout;
  logic dreq_n, dout_en, done, irq;
  int checks = 0, errors = 0;

  dma_hs_chan u0 (.*);

  localparam logic [7:0] VEC [6] = '{8'h80, 8'h06, 8'h00, 8'h01, 8'hC3, 8'h3C};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic kick(input logic d, input logic [7:0] a, input logic [7:0] c);
    @(negedge clk); start = 1; dir_in = d; addr_in = a; count_in = c;
    @(negedge clk); start = 0;
  endtask

  task automatic dma_wr(input logic [7:0] b, input int hold);
    @(negedge clk); dack_n = 0; wr_n = 0; din = b;
    for (int k = 0; k < hold; k++) @(negedge clk);
    wr_n = 1; dack_n = 1;
  endtask

  task automatic dma_rd(input logic [7:0] exp, input string req);
    @(negedge clk); dack_n = 0; rd_n = 0;
    #1 chk(req, dout, exp); chk(req, {7'd0, dout_en}, 8'd1);
    @(negedge clk); rd_n = 1; dack_n = 1;
  endtask

  task automatic cpu_wr(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk); cs_n = 0; wr_n = 0; cpu_addr = a; din = b;
    @(negedge clk); cs_n = 1; wr_n = 1;
  endtask

  task automatic cpu_rd(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); cs_n = 0; rd_n = 0; cpu_addr = a;
    #1 chk(req, dout, exp);
    @(negedge clk); cs_n = 1; rd_n = 1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; slave_mode = 1; start = 0; dir_in = 0; irq_en = 1;
    cs_n = 1; rd_n = 1; wr_n = 1; dack_n = 1;
    addr_in = 0; count_in = 0; cpu_addr = 0; din = 0;
    repeat (3) @(negedge clk);
    chk("R1 dreq_n", {7'd0, dreq_n}, 8'd1);
    chk("R1 done", {7'd0, done}, 8'd0);
    chk("R1 irq", {7'd0, irq}, 8'd0);
    chk("R1 dout_en", {7'd0, dout_en}, 8'd0);
    rst_n = 1;

    // R3: walk the vector table into RAM by DMA writes
    kick(1'b0, 8'h40, 8'd6);
    chk("R2 req low", {7'd0, dreq_n}, 8'd0);
    for (int i = 0; i < 6; i++) begin
      dma_wr(VEC[i], 1);
      if (i == 4) begin
        @(negedge clk);
        chk("R2 req held", {7'd0, dreq_n}, 8'd0);
        chk("R5 not done", {7'd0, done}, 8'd0);
      end
    end
    @(negedge clk);
    chk("R5 req off", {7'd0, dreq_n}, 8'd1);
    chk("R5 done", {7'd0, done}, 8'd1);
    chk("R9 irq", {7'd0, irq}, 8'd1);
    for (int i = 0; i < 6; i++) cpu_rd(8'h40 + 8'(i), VEC[i], "R3 stored");

    // R4: read the same bytes back out by DMA
    kick(1'b1, 8'h40, 8'd6);
    chk("R9 done cleared", {7'd0, done}, 8'd0);
    for (int i = 0; i < 6; i++) dma_rd(VEC[i], "R4 read");
    @(negedge clk);
    chk("R5 read done", {7'd0, done}, 8'd1);
    irq_en = 0; #1;
    chk("R9 irq masked", {7'd0, irq}, 8'd0);
    irq_en = 1;

    // R10: long strobe moves one byte
    cpu_wr(8'h82, 8'h33);
    kick(1'b0, 8'h80, 8'd2);
    dma_wr(8'hA5, 3);
    @(negedge clk);
    chk("R10 one byte", {7'd0, done}, 8'd0);
    dma_wr(8'h5A, 1);
    @(negedge clk);
    chk("R10 done", {7'd0, done}, 8'd1);
    cpu_rd(8'h80, 8'hA5, "R10 byte0");
    cpu_rd(8'h81, 8'h5A, "R10 byte1");
    cpu_rd(8'h82, 8'h33, "R10 untouched");

    // R8: processor access during an active run
    kick(1'b0, 8'h90, 8'd2);
    cpu_wr(8'hA0, 8'h77);
    chk("R8 req kept", {7'd0, dreq_n}, 8'd0);
    dma_wr(8'h11, 1);
    @(negedge clk);
    chk("R8 count intact", {7'd0, done}, 8'd0);
    dma_wr(8'h22, 1);
    @(negedge clk);
    chk("R8 done", {7'd0, done}, 8'd1);
    cpu_rd(8'hA0, 8'h77, "R8 cpu data");
    cpu_rd(8'h90, 8'h11, "R8 dma addr");
    cpu_rd(8'h91, 8'h22, "R8 dma next");

    // R6: zero count cancels and completes
    kick(1'b0, 8'h10, 8'd3);
    chk("R6 prior run", {7'd0, done}, 8'd0);
    kick(1'b0, 8'h10, 8'd0);
    chk("R6 done", {7'd0, done}, 8'd1);
    chk("R6 no req", {7'd0, dreq_n}, 8'd1);

    // R7: host mode ignores start, clearing mode aborts
    slave_mode = 0;
    kick(1'b0, 8'h20, 8'd4);
    chk("R7 host req", {7'd0, dreq_n}, 8'd1);
    chk("R7 host done", {7'd0, done}, 8'd1);
    slave_mode = 1;
    kick(1'b0, 8'h20, 8'd4);
    chk("R7 run", {7'd0, dreq_n}, 8'd0);
    slave_mode = 0;
    @(negedge clk);
    chk("R7 abort", {7'd0, dreq_n}, 8'd1);
    slave_mode = 1;
    @(negedge clk);
    chk("R7 stays off", {7'd0, dreq_n}, 8'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule